// File: doc/BRIEF.md
# Keyed Write Guard for Configuration Registers

This block sits beside a bank of configuration registers and decides, write by write, whether a store may land. It watches a plain write port made of a strobe, an address and a data word. It returns a one-cycle permit pulse on the line that belongs to the addressed register. The registers themselves live outside the block and update only when their permit line is high.

Two independent guards apply. The first is a key register with an ordered two-value unlock sequence. A permit granted through this sequence covers exactly one protected store, and the key relocks in the same cycle. The second is a sticky freeze bit held in the top bit of the control register. Once set, it keeps the control register, the crossbar register and every skip register frozen until reset. The current key phase and the freeze bit are both presented on output ports, so a status mux can read them back.

Registers sit on a 16-byte stride. With the default parameters the layout is:

- index 0 (0x00): an open register, never guarded.
- index 1 (0x10): the control register, whose bit 31 is the freeze bit.
- index 2 (0x20): the crossbar register.
- index 3 (0x30): the key register.
- indices 4 to 7 (0x40 to 0x70): the skip registers.

Top module: `keyed_write_guard`

## Requirements
- R1: Reset is synchronous and active high. After reset, `key_state` reads 0 (locked), `lock_state` reads 0, and every permit line is low.
- R2: In the locked phase, a write of 0xA5 to offset 0x30 moves `key_state` to 1 (half-open). Any other value written there leaves it at 0.
- R3: In the half-open phase, a write of `KEY_SECOND` (default 0xF1) to offset 0x30 moves `key_state` to 2 (open). The phase is visible on `key_state[7:0]` after the clock edge that samples the write.
- R4: In the half-open phase, a write to offset 0x30 with any value other than `KEY_SECOND` returns `key_state` to 0.
- R5: In the open phase, a write to a guarded register raises only that register's permit line, for the one cycle after the strobe edge. `key_state` reads 0 in that same cycle.
- R6: In the open phase, any write to offset 0x30, including 0xA5, returns `key_state` to 0. No permit is raised for that write.
- R7: A write to a guarded register (0x10, 0x20 or 0x40 to 0x70) while `key_state` is 0 or 1 raises no permit and leaves `key_state` unchanged.
- R8: A write to offset 0x00 is always permitted and never changes `key_state`.
- R9: A permitted write to offset 0x10 with data bit 31 set raises `lock_state` after the strobe edge.
- R10: While `lock_state` is 1, writes to 0x10, 0x20 and 0x40 to 0x70 are refused even in the open phase. Such a write still returns `key_state` to 0.
- R11: Once set, `lock_state` stays 1 until reset, whatever is written afterwards.
- R12: Only offsets that are multiples of 16 below 0x80 address a register. Any other address raises no permit and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| wr_permit | output | NUM_REGS | Registered one-cycle permit, one line per register index |
| key_state | output | 8 | Key phase: 0 locked, 1 half-open, 2 open |
| lock_state | output | 1 | Sticky freeze bit |

## Verification
The bench builds the block with its default parameters: eight register slots, an 8-bit address and a 0xF1 second key. With this configuration a sweep covers the entire address space and every possible key byte. All 256 first-key values are tried from the locked phase. All 256 second-key values are tried from the half-open phase. All 256 addresses are written in the open phase, with the freeze bit both clear and set. Together these sweeps reach every phase transition, every misaligned or out-of-range address, and every frozen slot. Expected permits and phases come from an arithmetic model of the requirements kept inside the bench.

// File: rtl/wguard_pkg.sv
package wguard_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } kphase_e;
endpackage

// File: rtl/wguard_decode.sv
module wguard_decode #(
  parameter int ADDR_W    = 8,
  parameter int STRIDE_LG = 4,
  parameter int NUM_REGS  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_REGS-1:0] hit
);
  localparam int IDX_W = ADDR_W - STRIDE_LG;

  logic aligned;
  assign aligned = (wr_addr[STRIDE_LG-1:0] == '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    assign hit[i] = wr_en && aligned && (wr_addr[ADDR_W-1:STRIDE_LG] == IDX_W'(i));
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R12
endmodule

// File: rtl/wguard_keyfsm.sv
module wguard_keyfsm
  import wguard_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'hA5,
  parameter logic [7:0] KEY_SECOND = 8'hF1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    key_wr,
  input  logic [7:0] key_data,
  input  logic    guarded_wr,
  output kphase_e phase
);
  kphase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      KS_LOCKED: if (key_wr && key_data == KEY_FIRST) nxt = KS_HALF;
      KS_HALF:   if (key_wr) nxt = (key_data == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
      KS_OPEN:   if (key_wr || guarded_wr) nxt = KS_LOCKED;
      default:   nxt = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= KS_LOCKED;
    else     phase <= nxt;
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase != kphase_e'(2'd3)); // R1
  AST_HALF_RESOLVES: assert property (@(posedge clk) disable iff (rst)
    (phase == KS_HALF && key_wr) |=> (phase != KS_HALF)); // R4
  AST_OPEN_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (phase == KS_OPEN && (key_wr || guarded_wr)) |=> (phase == KS_LOCKED)); // R6
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (phase == KS_LOCKED) |=> (phase != KS_OPEN)); // R2
endmodule

// File: rtl/wguard_lock.sv
module wguard_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (rst)          lock_q <= 1'b0;
    else if (set_req) lock_q <= 1'b1;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R11
endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard
  import wguard_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STRIDE_LG  = 4,
  parameter int NUM_REGS   = 8,
  parameter int KEY_IDX    = 3,
  parameter int CTRL_IDX   = 1,
  parameter int XBAR_IDX   = 2,
  parameter int SKIP_FIRST = 4,
  parameter int LOCK_BIT   = 31,
  parameter logic [NUM_REGS-1:0] GUARD_MASK = 8'hF6,
  parameter logic [7:0] KEY_FIRST  = 8'hA5,
  parameter logic [7:0] KEY_SECOND = 8'hF1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_REGS-1:0] wr_permit,
  output logic [7:0]          key_state,
  output logic                lock_state
);
  localparam logic [NUM_REGS-1:0] KEY_ONEHOT = NUM_REGS'(1) << KEY_IDX;
  localparam logic [NUM_REGS-1:0] GUARD_EFF  = GUARD_MASK & ~KEY_ONEHOT;
  localparam logic [NUM_REGS-1:0] OPEN_EFF   = ~GUARD_MASK & ~KEY_ONEHOT;

  function automatic logic [NUM_REGS-1:0] frozen_set();
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++)
      m[i] = (i == CTRL_IDX) || (i == XBAR_IDX) || (i >= SKIP_FIRST);
    return m & ~KEY_ONEHOT;
  endfunction
  localparam logic [NUM_REGS-1:0] FROZEN_MASK = frozen_set();

  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] grant;
  logic [NUM_REGS-1:0] guard_hit;
  kphase_e             phase;
  logic                lock_q;
  logic                is_open;

  wguard_decode #(
    .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .NUM_REGS(NUM_REGS)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
  );

  assign guard_hit = hit & GUARD_EFF;
  assign is_open   = (phase == KS_OPEN);

  always_comb begin
    grant = hit & OPEN_EFF;
    if (is_open)
      grant = grant | (guard_hit & ~(lock_q ? FROZEN_MASK : '0));
  end

  wguard_keyfsm #(
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .key_wr(hit[KEY_IDX]), .key_data(wr_data[7:0]),
    .guarded_wr(|guard_hit), .phase(phase)
  );

  wguard_lock u_lock (
    .clk(clk), .rst(rst),
    .set_req(grant[CTRL_IDX] && wr_data[LOCK_BIT]),
    .lock_q(lock_q)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_permit <= '0;
    else     wr_permit <= grant;
  end

  assign key_state  = {6'd0, phase};
  assign lock_state = lock_q;

  AST_PERMIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_permit)); // R5
  AST_PERMIT_RELOCKS: assert property (@(posedge clk) disable iff (rst)
    (|(wr_permit & GUARD_EFF)) |-> (key_state == 8'd0)); // R5
  AST_CLOSED_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!is_open && (|guard_hit)) |=> ((wr_permit & GUARD_EFF) == '0)); // R7
  AST_FROZEN_HELD: assert property (@(posedge clk) disable iff (rst)
    (lock_q && (|(hit & FROZEN_MASK))) |=> ((wr_permit & FROZEN_MASK) == '0)); // R10
  AST_KEY_NO_PERMIT: assert property (@(posedge clk) disable iff (rst)
    !wr_permit[KEY_IDX]); // R6
endmodule

// File: tb/keyed_write_guard_tb.sv
`timescale 1ns/1ps
module keyed_write_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  wr_permit;
  logic [7:0]  key_state;
  logic        lock_state;

  int checks = 0;
  int fails  = 0;
  int m_phase = 0;
  bit m_lock = 1'b0;

  always #4 clk = ~clk;

  keyed_write_guard u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_permit(wr_permit), .key_state(key_state), .lock_state(lock_state)
  );

  function automatic bit frozen(int i);
    return (i == 1) || (i == 2) || (i >= 4);
  endfunction

  task automatic compare(input string req, input logic [7:0] ep);
    checks++;
    if (wr_permit !== ep || key_state !== 8'(m_phase) || lock_state !== m_lock) begin
      fails++;
      $display("FAIL %s: permit=%h key=%0d lock=%0b expected permit=%h key=%0d lock=%0b",
               req, wr_permit, key_state, lock_state, ep, m_phase, m_lock);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_phase = 0;
    m_lock  = 1'b0;
    compare("R1", 8'h00);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    logic [7:0] ep;
    int idx;
    ep  = 8'h00;
    idx = int'(a[7:4]);
    if (a[3:0] == 4'h0 && idx < 8) begin
      if (idx == 3) begin
        if (m_phase == 0)      m_phase = (d[7:0] == 8'hA5) ? 1 : 0;
        else if (m_phase == 1) m_phase = (d[7:0] == 8'hF1) ? 2 : 0;
        else                   m_phase = 0;
      end else if (idx == 0) begin
        ep[0] = 1'b1;
      end else begin
        if (m_phase == 2) begin
          if (!(m_lock && frozen(idx))) begin
            ep[idx] = 1'b1;
            if (idx == 1 && d[31]) m_lock = 1'b1;
          end
          m_phase = 0;
        end
      end
    end
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    compare(req, ep);
  endtask

  task automatic unlock();
    wr(8'h30, 32'hA5, "R2");
    wr(8'h30, 32'hF1, "R3");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: every first-key value from the locked phase
    for (int v = 0; v < 256; v++) begin
      wr(8'h30, 32'(v), "R2");
      if (m_phase == 1) wr(8'h30, 32'h00, "R4");
    end
    // R3 / R4: every second-key value from the half-open phase
    for (int v = 0; v < 256; v++) begin
      wr(8'h30, 32'hA5, "R2");
      wr(8'h30, 32'(v), (v == 8'hF1) ? "R3" : "R4");
      if (m_phase == 2) wr(8'h30, 32'hA5, "R6");
    end
    // R7: guarded writes while locked and half-open
    for (int i = 0; i < 8; i++) begin
      if (i == 3) continue;
      wr(8'(i * 16), 32'hFFFF_FFFF, (i == 0) ? "R8" : "R7");
      wr(8'h30, 32'hA5, "R2");
      wr(8'(i * 16), 32'hFFFF_FFFF, (i == 0) ? "R8" : "R7");
      wr(8'h30, 32'h11, "R4");
    end
    // R5 / R8 / R12: every address in the open phase, freeze clear
    for (int a = 0; a < 256; a++) begin
      unlock();
      wr(8'(a), 32'h0, (a[3:0] != 0 || a >= 128) ? "R12" : (a == 0 ? "R8" : "R5"));
      if (m_phase == 2) wr(8'h30, 32'h0, "R6");
    end
    // R9: set the freeze bit
    unlock();
    wr(8'h10, 32'h8000_0000, "R9");
    // R10 / R11: every address in the open phase, freeze set
    for (int a = 0; a < 256; a++) begin
      unlock();
      wr(8'(a), 32'h0, (a[3:0] != 0 || a >= 128) ? "R12" : "R10");
      if (m_phase == 2) wr(8'h30, 32'hA5, "R6");
    end
    unlock();
    wr(8'h10, 32'h0, "R11");
    wr(8'h00, 32'h0, "R11");
    // R1: reset clears the freeze bit
    do_reset();
    unlock();
    wr(8'h20, 32'h0, "R5");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule